// File: doc/BRIEF.md
# Misaligned Transfer Splitter

This block takes one operand access (byte, word or longword at any byte address) and turns it into a series of bus transfers. Each transfer is naturally aligned and no wider than the port it targets. The port can be 8, 16 or 32 bits wide. For each transfer the block gives the address and a 2-bit size code. That code describes the transfer itself, not the operand it belongs to.

An access is accepted with a valid/ready handshake. The transfers then come out one at a time on a second valid/ready handshake. A final flag marks the transfer that completes the operand. The port width is sampled together with the request and is held for the whole operand. The block does not move operand bytes into lanes, and it does not generate bus timing.

Top module: `misalign_splitter`

## Requirements
- R1: Size codes on `req_size` and `xfer_size` are 2'b01 = byte, 2'b10 = word, 2'b00 = longword; `req_size` 2'b11 is treated as longword. `port_width` uses 2'b01 = 8-bit, 2'b10 = 16-bit, and 2'b00 or 2'b11 = 32-bit.
- R2: While reset is held and just after it, `req_ready` is 1 and `xfer_valid` is 0.
- R3: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) raises `xfer_valid` in the next cycle. The first transfer starts at the operand address. `req_ready` stays 0 while transfers are pending.
- R4: Each transfer has the largest of 4, 2 or 1 bytes that satisfies three limits: it is no wider than the port, no larger than the bytes still outstanding, and its address is a multiple of that size.
- R5: Each following transfer starts at the previous address plus the previous transfer's size in bytes. The transfer sizes add up to the operand size.
- R6: `xfer_last` is 1 on the final transfer only. An aligned access that fits the port gives exactly one transfer, with `xfer_last` set.
- R7: The block moves to the next transfer only at an edge where both `xfer_valid` and `xfer_ready` are 1. While `xfer_ready` is 0, the address, size and last flag hold their values.
- R8: `req_valid` has no effect while transfers are pending. The cycle after the final handshake, `req_ready` is 1 and `xfer_valid` is 0.
- R9: A longword at byte offset 1 on a 32-bit port comes out as three transfers: a byte at offset 1, then a word at offset 2, then a byte at offset 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand access request |
| req_ready | output | 1 | Block is free to accept a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| port_width | input | 2 | Port width code, sampled with the request |
| xfer_valid | output | 1 | A transfer is presented |
| xfer_ready | input | 1 | Bus side takes the current transfer |
| xfer_addr | output | ADDR_W | Transfer byte address |
| xfer_size | output | 2 | Transfer size code |
| xfer_last | output | 1 | Transfer completes the operand |

## Verification
The splitter is tested with every operand size at every byte offset that matters, on each of the three port widths.

- Aligned cases that fit the port show that a single transfer is produced.
- Offsets 1 and 3 show whether byte pieces are placed on both sides of a word.
- Narrow ports show that a transfer is capped by the port width and not by the alignment.

The reserved size and port codes are included to confirm that they fall back to longword and 32-bit. Stalls on the transfer side, with extra requests driven during them, show that pieces advance only on a handshake and that a busy block ignores new requests.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
   localparam int LOG2_MAX = 2;
   localparam int REM_W    = LOG2_MAX + 1;

   typedef logic [1:0]       code_t;
   typedef logic [REM_W-1:0] rem_t;

   localparam code_t SZ_BYTE = 2'b01;
   localparam code_t SZ_WORD = 2'b10;
   localparam code_t SZ_LONG = 2'b00;

   function automatic logic [1:0] code_log2(input code_t c);
      case (c)
         SZ_BYTE: return 2'd0;
         SZ_WORD: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   function automatic code_t log2_code(input logic [1:0] l);
      case (l)
         2'd0:    return SZ_BYTE;
         2'd1:    return SZ_WORD;
         default: return SZ_LONG;
      endcase
   endfunction
endpackage

// File: rtl/msplit_pick.sv
module msplit_pick
   import msplit_pkg::*;
(
   input  logic [LOG2_MAX-1:0] addr_lo,
   input  rem_t                remain,
   input  logic [1:0]          port_l2,
   output logic [1:0]          pick_l2
);
   localparam int NCAND = LOG2_MAX + 1;
   typedef logic [LOG2_MAX-1:0] lo_t;

   logic [NCAND-1:0] fits;

   for (genvar k = 0; k < NCAND; k++) begin : g_cand
      localparam rem_t SZ   = rem_t'(1 << k);
      localparam lo_t  MASK = lo_t'((1 << k) - 1);
      assign fits[k] = (port_l2 >= 2'(k)) && (remain >= SZ) && ((addr_lo & MASK) == '0);
   end

   always_comb begin
      pick_l2 = 2'd0;
      for (int k = 0; k < NCAND; k++) begin
         if (fits[k]) pick_l2 = 2'(k);
      end
   end
endmodule

// File: rtl/msplit_track.sv
module msplit_track
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  code_t             req_size,
   input  code_t             port_width,
   input  logic              xfer_ready,
   input  logic [1:0]        pick_l2,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output rem_t              remain,
   output logic [1:0]        port_l2,
   output logic              last
);
   rem_t piece_bytes;

   assign piece_bytes = rem_t'(1) << pick_l2;
   assign last        = (piece_bytes == remain);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         port_l2  <= 2'd2;
      end else if (!busy) begin
         if (req_valid) begin
            busy     <= 1'b1;
            cur_addr <= req_addr;
            remain   <= rem_t'(1) << code_log2(req_size);
            port_l2  <= code_log2(port_width);
         end
      end else if (xfer_ready) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            cur_addr <= cur_addr + ADDR_W'(piece_bytes);
            remain   <= remain - piece_bytes;
         end
      end
   end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [1:0]        port_width,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [1:0]        xfer_size,
   output logic              xfer_last
);
   if (ADDR_W < LOG2_MAX + 1) begin : g_bad_width
      $error("misalign_splitter: ADDR_W too small");
   end

   logic              busy;
   logic [ADDR_W-1:0] cur_addr;
   rem_t              remain;
   logic [1:0]        port_l2;
   logic [1:0]        pick_l2;
   logic              last;

   msplit_track #(.ADDR_W(ADDR_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_size   (req_size),
      .port_width (port_width),
      .xfer_ready (xfer_ready),
      .pick_l2    (pick_l2),
      .busy       (busy),
      .cur_addr   (cur_addr),
      .remain     (remain),
      .port_l2    (port_l2),
      .last       (last)
   );

   msplit_pick u_pick (
      .addr_lo (cur_addr[LOG2_MAX-1:0]),
      .remain  (remain),
      .port_l2 (port_l2),
      .pick_l2 (pick_l2)
   );

   assign req_ready  = !busy;
   assign xfer_valid = busy;
   assign xfer_addr  = cur_addr;
   assign xfer_size  = log2_code(pick_l2);
   assign xfer_last  = busy && last;
endmodule

// File: rtl/msplit_chk.sv
module msplit_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        port_width,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [1:0]        xfer_size,
   input logic              xfer_last
);
   function automatic logic [2:0] nbytes(input logic [1:0] c);
      case (c)
         2'b01:   return 3'd1;
         2'b10:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   logic [2:0] port_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    port_seen <= 3'd4;
      else if (req_valid && req_ready) port_seen <= nbytes(port_width);
   end

   // R3
   start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> xfer_valid && xfer_addr == $past(req_addr));

   // R3
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> !req_ready);

   // R4
   natural_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_addr[1:0] & 2'(nbytes(xfer_size) - 3'd1)) == 2'b00);

   // R4
   port_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> nbytes(xfer_size) <= port_seen);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready && !xfer_last |=>
         xfer_valid && xfer_addr == $past(xfer_addr) + ADDR_W'(nbytes($past(xfer_size))));

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=>
         xfer_valid && $stable(xfer_addr) && $stable(xfer_size) && $stable(xfer_last));

   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready && xfer_last |=> req_ready && !xfer_valid);
endmodule

bind misalign_splitter msplit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .port_width (port_width),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_addr  (xfer_addr),
   .xfer_size  (xfer_size),
   .xfer_last  (xfer_last)
);

// File: tb/misalign_splitter_bench.sv
module misalign_splitter_bench;
   localparam int NV = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = 2'b01;
   logic [1:0]  port_width = 2'b00;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [31:0] xfer_addr;
   logic [1:0]  xfer_size;
   logic        xfer_last;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   misalign_splitter #(.ADDR_W(32)) u_misalign_splitter (.*);

   // {addr, size code, port code, expected transfer count}
   localparam logic [39:0] VEC [NV] = '{
      {32'h1000_0000, 2'b00, 2'b00, 4'd1},
      {32'h1000_0001, 2'b00, 2'b00, 4'd3},
      {32'h1000_0002, 2'b00, 2'b00, 4'd2},
      {32'h1000_0003, 2'b00, 2'b00, 4'd3},
      {32'h2000_0010, 2'b00, 2'b10, 4'd2},
      {32'h2000_0011, 2'b00, 2'b10, 4'd3},
      {32'h3000_0020, 2'b00, 2'b01, 4'd4},
      {32'h3000_0022, 2'b00, 2'b01, 4'd4},
      {32'h4000_0001, 2'b10, 2'b00, 4'd2},
      {32'h4000_0002, 2'b10, 2'b00, 4'd1},
      {32'h4000_0003, 2'b10, 2'b10, 4'd2},
      {32'h4000_0004, 2'b10, 2'b01, 4'd2},
      {32'h5000_0003, 2'b01, 2'b00, 4'd1},
      {32'h6000_0008, 2'b11, 2'b11, 4'd1},
      {32'h6000_0006, 2'b11, 2'b10, 4'd2}
   };

   function automatic int nbytes(input logic [1:0] c);
      if (c == 2'b01) return 1;
      if (c == 2'b10) return 2;
      return 4;
   endfunction

   function automatic logic [1:0] code_of(input int b);
      if (b == 1) return 2'b01;
      if (b == 2) return 2'b10;
      return 2'b00;
   endfunction

   // largest aligned piece within port and outstanding bytes (R4)
   function automatic int ref_piece(input logic [31:0] a, input int rem, input int pw);
      for (int s = 4; s >= 1; s = s / 2) begin
         if (s <= pw && s <= rem && (a % s) == 0) return s;
      end
      return 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] pw,
                         input int exp_n, input int stall);
      int m_rem;
      int pwb;
      int n;
      logic [31:0] m_addr;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_addr = a; req_size = sz; port_width = pw; xfer_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      port_width = 2'b01;   // change after sampling: must not matter
      m_addr = a; m_rem = nbytes(sz); pwb = nbytes(pw); n = 0;
      while (m_rem > 0) begin
         int p;
         p = ref_piece(m_addr, m_rem, pwb);
         chk(xfer_valid && !req_ready, "R3", "valid/busy", {62'd0, xfer_valid, req_ready}, 64'd2);
         chk(xfer_addr == m_addr, "R5", "addr", 64'(xfer_addr), 64'(m_addr));
         chk(xfer_size == code_of(p), "R4", "size code (R1)", 64'(xfer_size), 64'(code_of(p)));
         chk(xfer_last == (p == m_rem), "R6", "last", 64'(xfer_last), 64'(p == m_rem));
         for (int s = 0; s < stall; s++) begin
            req_valid = 1'b1; req_addr = 32'hDEAD_BEE1; req_size = 2'b01;
            @(negedge clk);
            chk(xfer_addr == m_addr && xfer_size == code_of(p) && xfer_valid,
                "R7", "held during stall", 64'(xfer_addr), 64'(m_addr));
         end
         req_valid = 1'b0;
         xfer_ready = 1'b1;
         @(negedge clk);
         xfer_ready = 1'b0;
         m_addr = m_addr + 32'(p);
         m_rem = m_rem - p;
         n++;
      end
      chk(n == exp_n, "R5", "transfer count", 64'(n), 64'(exp_n));
      chk(!xfer_valid && req_ready, "R8", "idle after last", {62'd0, xfer_valid, req_ready}, 64'd1);
   endtask

   initial begin
      #1;
      chk(req_ready == 1'b1 && xfer_valid == 1'b0, "R2", "in reset",
          {62'd0, req_ready, xfer_valid}, 64'd2);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && xfer_valid == 1'b0, "R2", "after reset",
          {62'd0, req_ready, xfer_valid}, 64'd2);

      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][39:8], VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]), i % 3);
      end

      // R9: the stated misaligned longword example, hand expectations
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_0101; req_size = 2'b00; port_width = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      chk(xfer_addr == 32'h101 && xfer_size == 2'b01 && !xfer_last, "R9", "piece 1",
          {xfer_addr, 30'd0, xfer_size}, {32'h101, 30'd0, 2'b01});
      xfer_ready = 1'b1;
      @(negedge clk);
      chk(xfer_addr == 32'h102 && xfer_size == 2'b10 && !xfer_last, "R9", "piece 2",
          {xfer_addr, 30'd0, xfer_size}, {32'h102, 30'd0, 2'b10});
      @(negedge clk);
      chk(xfer_addr == 32'h104 && xfer_size == 2'b01 && xfer_last, "R9", "piece 3",
          {xfer_addr, 30'd0, xfer_size}, {32'h104, 30'd0, 2'b01});
      @(negedge clk);
      xfer_ready = 1'b0;
      chk(!xfer_valid, "R8", "done after R9 op", 64'(xfer_valid), 64'd0);

      // R6: aligned word on 16-bit port is one final transfer; R1 byte-port code
      run_op(32'h7000_0002, 2'b10, 2'b10, 1, 0);
      run_op(32'h7000_0001, 2'b01, 2'b01, 1, 2);

      // reset while busy returns to idle (R2)
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h8000_0001; req_size = 2'b00; port_width = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(req_ready && !xfer_valid, "R2", "reset while busy",
          {62'd0, req_ready, xfer_valid}, 64'd2);
      @(negedge clk);
      rst_n = 1'b1;
      run_op(32'h8000_0004, 2'b00, 2'b00, 1, 0);

      summary();
   end

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule